// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single channel of a three-channel programmable interval timer. It holds a 16-bit down counter that steps once for each cycle in which the count-enable strobe is high. Software programs the channel with an 8-bit control word and moves the reload value and the count one byte at a time through a byte-wide data port. A latch command freezes a copy of the count, so a multi-byte read returns one consistent value.

The channel drives one output pin whose waveform follows six operating modes: a terminal-count flag, a gate-triggered one-shot, a rate generator, a square wave, a software strobe and a gate-triggered strobe. The gate input starts or restarts the count in the triggered modes and pauses counting in the others. A parameter gives the channel index that the control word's select field must match, so three copies can share one control strobe.

Top module: `pit_channel`

## Requirements
- R1: A control word (ctrl_we with wdata) is taken only when bits 7:6 equal CHAN_ID. Any other select value, including 3, has no effect. Bits 5:4 are the access mode (0 latch, 1 low byte only, 2 high byte only, 3 low then high). Bits 3:1 are the operating mode, with 6 and 7 acting as 2 and 3. Bit 0 is ignored and counting is always binary.
- R2: Out of reset the channel is in mode 0 with low-then-high access, out_pin low and count 0. A control word with a nonzero access mode sets both byte pointers to the low byte. It drives out_pin low in mode 0 and high in every other mode, and it stops counting until a count has been written in full.
- R3: Count writes (data_we): low-only loads bits 7:0 and clears bits 15:8. High-only loads bits 15:8 and clears bits 7:0. Low-then-high takes the low byte first and the high byte second, and the value takes effect on the second byte.
- R4: Reads (data_re pulse ends a byte read; rdata shows the byte beforehand): low-only returns bits 7:0, high-only returns bits 15:8, and low-then-high alternates low then high.
- R5: A latch command captures the current count. A second latch before that copy is fully read is ignored. Once the copy has been fully read, reads return the live count.
- R6: Mode 0: after a load, out_pin stays low until the step that brings the count to zero, then stays high while the counter keeps wrapping down.
- R7: Mode 1: a written count waits for a gate rising edge. That edge loads the count and drives out_pin low, and out_pin returns high when the count reaches zero. A later rising edge reloads the count, and the gate level does not pause counting.
- R8: Mode 2: out_pin goes low on the step that brings the count to 1. On the next step the count reloads the period and out_pin returns high.
- R9: Mode 3: the count steps down by two from the period rounded down to even. Each time it would reach zero it reloads and out_pin toggles, so an even period N gives N/2 steps high and N/2 steps low.
- R10: Mode 4: a fully written count starts counting. On the step that reaches zero out_pin goes low for one step, then returns high and counting stops.
- R11: Mode 5: like mode 4, but counting starts on a gate rising edge after the count has been written.
- R12: In modes 0, 2, 3 and 4, the count holds while gate is low.
- R13: A period of 0 acts as 65536: the first step takes the count to 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| cnt_en | input | 1 | Count-enable strobe, one counter step per high cycle |
| gate | input | 1 | Gate: trigger in modes 1 and 5, count enable in the others |
| ctrl_we | input | 1 | Control word write strobe |
| data_we | input | 1 | Count byte write strobe |
| data_re | input | 1 | Count byte read strobe, advances the read pointer |
| wdata | input | 8 | Control word or count byte |
| rdata | output | 8 | Byte selected by the read pointer and latch state |
| out_pin | output | 1 | Channel output waveform |

## Verification
The assertions take for granted that ctrl_we and data_we are never high in the same cycle, and that every strobe and the gate are synchronous to clk. They also assume a byte read is signalled by a single one-cycle data_re pulse. The bench keeps within these limits by driving one strobe at a time, just after a rising edge, and by pulsing data_re for exactly one cycle per byte it samples. Gate edges are separated by at least one full clock, so each edge reaches the gate history register as a single rising edge.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = CNT_W / 2;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_BOTH  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    M_TC     = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE   = 3'd2,
    M_SQUARE = 3'd3,
    M_SWSTB  = 3'd4,
    M_HWSTB  = 3'd5
  } mode_e;

  function automatic mode_e norm_mode(input logic [2:0] m);
    case (m)
      3'd6:    return M_RATE;
      3'd7:    return M_SQUARE;
      default: return mode_e'(m);
    endcase
  endfunction
endpackage

// File: rtl/pit_access.sv
module pit_access
  import pit_pkg::*;
#(
  parameter int CHAN_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              data_we,
  input  logic              data_re,
  input  logic [BYTE_W-1:0] din,
  input  logic [CNT_W-1:0]  live_cnt,
  output logic [BYTE_W-1:0] dout,
  output mode_e             mode_q,
  output mode_e             mode_nx,
  output logic              ctrl_go,
  output logic              load_go,
  output logic [CNT_W-1:0]  period_q,
  output logic [CNT_W-1:0]  period_nx
);
  localparam logic [1:0] SEL_ME = CHAN_ID[1:0];

  acc_e              acc_q, acc_nx, acc_f;
  logic              wr_ptr_q, wr_ptr_nx, rd_ptr_q, rd_ptr_nx;
  logic              latch_q, latch_nx;
  logic [CNT_W-1:0]  latched_q, latched_nx, rd_src;
  logic              hit, latch_cmd, data_ok, rd_hi, rd_final, wr_final;

  // control word decode
  always_comb begin
    acc_f     = acc_e'(din[5:4]);
    hit       = ctrl_we && (din[7:6] == SEL_ME);
    ctrl_go   = hit && (acc_f != ACC_LATCH);
    latch_cmd = hit && (acc_f == ACC_LATCH);
    data_ok   = data_we && !ctrl_we;
    wr_final  = (acc_q != ACC_BOTH) || wr_ptr_q;
    load_go   = data_ok && wr_final;
    rd_final  = (acc_q != ACC_BOTH) || rd_ptr_q;
    rd_hi     = (acc_q == ACC_HI) || ((acc_q == ACC_BOTH) && rd_ptr_q);
    rd_src    = latch_q ? latched_q : live_cnt;
    dout      = rd_hi ? rd_src[CNT_W-1:BYTE_W] : rd_src[BYTE_W-1:0];
  end

  // next state
  always_comb begin
    acc_nx     = acc_q;
    mode_nx    = mode_q;
    wr_ptr_nx  = wr_ptr_q;
    rd_ptr_nx  = rd_ptr_q;
    latch_nx   = latch_q;
    latched_nx = latched_q;
    period_nx  = period_q;
    case (acc_q)
      ACC_LO:   period_nx = {{BYTE_W{1'b0}}, din};
      ACC_HI:   period_nx = {din, {BYTE_W{1'b0}}};
      ACC_BOTH: period_nx = wr_ptr_q ? {din, period_q[BYTE_W-1:0]}
                                     : {period_q[CNT_W-1:BYTE_W], din};
      default:  period_nx = period_q;
    endcase
    if (ctrl_go) begin
      acc_nx    = acc_f;
      mode_nx   = norm_mode(din[3:1]);
      wr_ptr_nx = 1'b0;
      rd_ptr_nx = 1'b0;
      latch_nx  = 1'b0;
    end else begin
      if (data_ok && (acc_q == ACC_BOTH)) wr_ptr_nx = !wr_ptr_q;
      if (data_re && (acc_q == ACC_BOTH)) rd_ptr_nx = !rd_ptr_q;
      if (latch_cmd && !latch_q) begin
        latch_nx   = 1'b1;
        latched_nx = live_cnt;
      end else if (data_re && latch_q && rd_final) begin
        latch_nx = 1'b0;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= ACC_BOTH;
      mode_q    <= M_TC;
      wr_ptr_q  <= 1'b0;
      rd_ptr_q  <= 1'b0;
      latch_q   <= 1'b0;
      latched_q <= '0;
      period_q  <= '0;
    end else begin
      acc_q    <= acc_nx;
      mode_q   <= mode_nx;
      wr_ptr_q <= wr_ptr_nx;
      rd_ptr_q <= rd_ptr_nx;
      latch_q  <= latch_nx;
      if (latch_cmd && !latch_q) latched_q <= latched_nx;
      if (data_ok) period_q <= period_nx;
    end
  end

  // R3
  ptr_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q != ACC_BOTH) |-> (!wr_ptr_q && !rd_ptr_q));

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !ctrl_go) |=> $stable(latched_q));
endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             gate,
  input  logic             ctrl_go,
  input  mode_e            mode_nx,
  input  mode_e            mode_q,
  input  logic             load_go,
  input  logic [CNT_W-1:0] period_nx,
  input  logic [CNT_W-1:0] period_q,
  output logic [CNT_W-1:0] count_q,
  output logic             out_q
);
  logic [CNT_W-1:0] count_nx;
  logic             out_nx, armed_q, armed_nx, loaded_q, loaded_nx;
  logic             gate_q, gate_rise, trig_mode, step;

  always_comb begin
    gate_rise = gate && !gate_q;
    trig_mode = (mode_q == M_ONESHOT) || (mode_q == M_HWSTB);
    step      = armed_q && cnt_en && (trig_mode || gate);
  end

  always_comb begin
    count_nx  = count_q;
    out_nx    = out_q;
    armed_nx  = armed_q;
    loaded_nx = loaded_q;
    if (ctrl_go) begin
      armed_nx  = 1'b0;
      loaded_nx = 1'b0;
      out_nx    = (mode_nx != M_TC);
    end else if (load_go) begin
      loaded_nx = 1'b1;
      if (!trig_mode) begin
        armed_nx = 1'b1;
        count_nx = (mode_q == M_SQUARE) ? {period_nx[CNT_W-1:1], 1'b0} : period_nx;
        out_nx   = (mode_q != M_TC);
      end
    end else if (trig_mode && loaded_q && gate_rise) begin
      armed_nx = 1'b1;
      count_nx = period_q;
      out_nx   = (mode_q != M_ONESHOT);
    end else if (step) begin
      case (mode_q)
        M_TC, M_ONESHOT: begin
          count_nx = count_q - CNT_W'(1);
          if (count_q == CNT_W'(1)) out_nx = 1'b1;
        end
        M_RATE: begin
          if (count_q == CNT_W'(1)) begin
            count_nx = period_q;
            out_nx   = 1'b1;
          end else begin
            count_nx = count_q - CNT_W'(1);
            if (count_q == CNT_W'(2)) out_nx = 1'b0;
          end
        end
        M_SQUARE: begin
          if (count_q == CNT_W'(2)) begin
            count_nx = {period_q[CNT_W-1:1], 1'b0};
            out_nx   = !out_q;
          end else begin
            count_nx = count_q - CNT_W'(2);
          end
        end
        M_SWSTB, M_HWSTB: begin
          if (count_q == CNT_W'(1)) begin
            count_nx = '0;
            out_nx   = 1'b0;
          end else if ((count_q == '0) && !out_q) begin
            out_nx   = 1'b1;
            armed_nx = 1'b0;
          end else begin
            count_nx = count_q - CNT_W'(1);
          end
        end
        default: count_nx = count_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      out_q    <= 1'b0;
      armed_q  <= 1'b0;
      loaded_q <= 1'b0;
      gate_q   <= 1'b0;
    end else begin
      count_q  <= count_nx;
      out_q    <= out_nx;
      armed_q  <= armed_nx;
      loaded_q <= loaded_nx;
      gate_q   <= gate;
    end
  end

  // R2
  stop_on_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_go |=> !armed_q);

  // R6
  tc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_TC && out_q && !ctrl_go && !load_go) |=> out_q);

  // R8
  rate_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RATE && !out_q && step && !ctrl_go && !load_go) |=> out_q);

  // R9
  square_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SQUARE && armed_q) |-> !count_q[0]);
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CHAN_ID = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_en,
  input  logic       gate,
  input  logic       ctrl_we,
  input  logic       data_we,
  input  logic       data_re,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       out_pin
);
  logic [1:0]       rst_sync_q;
  logic             rst_s;
  mode_e            mode_q, mode_nx;
  logic             ctrl_go, load_go;
  logic [CNT_W-1:0] period_q, period_nx, count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  pit_access #(.CHAN_ID(CHAN_ID)) u_access (
    .clk      (clk),
    .rst_n    (rst_s),
    .ctrl_we  (ctrl_we),
    .data_we  (data_we),
    .data_re  (data_re),
    .din      (wdata),
    .live_cnt (count_q),
    .dout     (rdata),
    .mode_q   (mode_q),
    .mode_nx  (mode_nx),
    .ctrl_go  (ctrl_go),
    .load_go  (load_go),
    .period_q (period_q),
    .period_nx(period_nx)
  );

  pit_counter u_counter (
    .clk      (clk),
    .rst_n    (rst_s),
    .cnt_en   (cnt_en),
    .gate     (gate),
    .ctrl_go  (ctrl_go),
    .mode_nx  (mode_nx),
    .mode_q   (mode_q),
    .load_go  (load_go),
    .period_nx(period_nx),
    .period_q (period_q),
    .count_q  (count_q),
    .out_q    (out_pin)
  );
endmodule

// File: tb/pit_channel_tb.sv
module pit_channel_tb;
  localparam int CLK_P = 10;

  logic       clk, rst_n, cnt_en, gate, ctrl_we, data_we, data_re;
  logic [7:0] wdata, rdata;
  logic       out_pin;
  int         n_chk, n_err;

  pit_channel #(.CHAN_ID(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate(gate),
    .ctrl_we(ctrl_we), .data_we(data_we), .data_re(data_re),
    .wdata(wdata), .rdata(rdata), .out_pin(out_pin)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = !clk;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] cw(input int sel, input int acc, input int md, input bit bcd);
    return {sel[1:0], acc[1:0], md[2:0], bcd};
  endfunction

  task automatic wctl(input logic [7:0] b);
    ctrl_we = 1'b1; wdata = b; tick(); ctrl_we = 1'b0;
  endtask

  task automatic wdat(input logic [7:0] b);
    data_we = 1'b1; wdata = b; tick(); data_we = 1'b0;
  endtask

  task automatic rd(output logic [7:0] b);
    b = rdata; data_re = 1'b1; tick(); data_re = 1'b0;
  endtask

  task automatic rd16(output int v);
    logic [7:0] lo, hi;
    rd(lo); rd(hi); v = {hi, lo};
  endtask

  task automatic steps(input int n);
    cnt_en = 1'b1;
    for (int i = 0; i < n; i++) tick();
    cnt_en = 1'b0;
  endtask

  task automatic t_reset();
    int v;
    chk("R2 reset out", out_pin, 0);
    rd16(v); chk("R2 reset count", v, 0);
  endtask

  task automatic t_select();
    int v;
    wctl(cw(1, 1, 2, 0)); chk("R1 other select out", out_pin, 0);
    wctl(cw(3, 1, 2, 0)); chk("R1 select 3 out", out_pin, 0);
    wdat(8'h34); wdat(8'h12);
    rd16(v); chk("R1 R3 two-phase load", v, 16'h1234);
  endtask

  task automatic t_mode0();
    int v, w;
    wctl(cw(0, 3, 0, 0)); chk("R2 mode0 out low", out_pin, 0);
    wdat(8'h05);
    rd16(v); steps(3); rd16(w);
    chk("R2 no count before full write", w, v);
    wdat(8'h00);
    rd16(v); chk("R3 loaded on second byte", v, 5);
    steps(4); rd16(v); chk("R6 count 1", v, 1); chk("R6 out low", out_pin, 0);
    steps(1); chk("R6 out high at zero", out_pin, 1);
    steps(1); rd16(v); chk("R6 wraps", v, 16'hFFFF); chk("R6 out stays high", out_pin, 1);
  endtask

  task automatic t_gate();
    int v;
    wctl(cw(0, 3, 0, 0)); wdat(8'd10); wdat(8'd0);
    gate = 1'b0; steps(5); rd16(v); chk("R12 held by gate", v, 10);
    gate = 1'b1; steps(3); rd16(v); chk("R12 resumes", v, 7);
  endtask

  task automatic t_single();
    logic [7:0] b;
    wctl(cw(0, 1, 0, 0)); wdat(8'h07);
    rd(b); chk("R4 low-only read", b, 8'h07);
    rd(b); chk("R4 low-only again", b, 8'h07);
    steps(2); rd(b); chk("R4 low-only live", b, 8'h05);
    steps(4); chk("R3 high cleared out low", out_pin, 0);
    steps(1); chk("R3 high cleared out high", out_pin, 1);
    wctl(cw(0, 2, 0, 0)); wdat(8'h02);
    rd(b); chk("R4 high-only read", b, 8'h02);
    steps(1); rd(b); chk("R3 R4 low cleared", b, 8'h01);
  endtask

  task automatic t_latch();
    int v;
    wctl(cw(0, 3, 0, 0)); wdat(8'h20); wdat(8'h01);
    wctl(cw(0, 0, 0, 0));
    steps(5);
    wctl(cw(0, 0, 0, 0));
    steps(1);
    rd16(v); chk("R5 first snapshot", v, 16'h0120);
    rd16(v); chk("R5 released live", v, 16'h011A);
  endtask

  task automatic t_rate();
    int v;
    wctl(cw(0, 3, 2, 0)); chk("R2 mode2 out high", out_pin, 1);
    wdat(8'd3); wdat(8'd0);
    steps(1); chk("R8 out at 2", out_pin, 1);
    steps(1); chk("R8 low at 1", out_pin, 0);
    steps(1); rd16(v); chk("R8 reload", v, 3); chk("R8 high after reload", out_pin, 1);
  endtask

  task automatic t_square();
    int v;
    int exp_out[6] = '{1, 1, 0, 0, 0, 1};
    wctl(cw(0, 3, 7, 1)); wdat(8'd6); wdat(8'd0);
    steps(1); rd16(v); chk("R9 R1 binary step by two", v, 4);
    chk("R9 out step1", out_pin, exp_out[0]);
    for (int i = 1; i < 6; i++) begin
      steps(1); chk("R9 square out", out_pin, exp_out[i]);
    end
  endtask

  task automatic t_swstb();
    int v;
    wctl(cw(0, 3, 4, 0)); wdat(8'd3); wdat(8'd0);
    steps(2); chk("R10 high before zero", out_pin, 1);
    steps(1); chk("R10 strobe low", out_pin, 0);
    steps(1); chk("R10 back high", out_pin, 1);
    steps(2); rd16(v); chk("R10 stopped", v, 0); chk("R10 stays high", out_pin, 1);
  endtask

  task automatic t_oneshot();
    int v;
    wctl(cw(0, 3, 1, 0)); wdat(8'd3); wdat(8'd0);
    steps(2); chk("R7 waits for trigger", out_pin, 1);
    gate = 1'b0; tick(); gate = 1'b1; tick();
    chk("R7 out low on trigger", out_pin, 0);
    rd16(v); chk("R7 loaded on trigger", v, 3);
    steps(2); chk("R7 low before zero", out_pin, 0);
    steps(1); chk("R7 high at zero", out_pin, 1);
    gate = 1'b0; tick(); gate = 1'b1; tick();
    rd16(v); chk("R7 retrigger", v, 3); chk("R7 retrigger out", out_pin, 0);
    gate = 1'b0; steps(1); rd16(v); chk("R7 gate level ignored", v, 2);
    gate = 1'b1;
  endtask

  task automatic t_hwstb();
    int v;
    wctl(cw(0, 3, 5, 0)); wdat(8'd2); wdat(8'd0);
    gate = 1'b0; tick(); gate = 1'b1; tick();
    rd16(v); chk("R11 loaded on trigger", v, 2); chk("R11 out high", out_pin, 1);
    steps(1); chk("R11 high at 1", out_pin, 1);
    steps(1); chk("R11 strobe low", out_pin, 0);
    steps(1); chk("R11 back high", out_pin, 1);
  endtask

  task automatic t_zero();
    int v;
    wctl(cw(0, 3, 0, 0)); wdat(8'd0); wdat(8'd0);
    steps(1); rd16(v); chk("R13 zero is 65536", v, 16'hFFFF);
    chk("R13 out still low", out_pin, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0;
    rst_n = 1'b0; cnt_en = 1'b0; gate = 1'b1;
    ctrl_we = 1'b0; data_we = 1'b0; data_re = 1'b0; wdata = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_select();
    t_mode0();
    t_gate();
    t_single();
    t_latch();
    t_rate();
    t_square();
    t_swstb();
    t_oneshot();
    t_hwstb();
    t_zero();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule